// File: doc/BRIEF.md
# Unsigned Bitfield Move Unit

This unit is an execution datapath that moves a field of bits out of a 64-bit source operand into a result in which every other bit is zero. It works in a 32-bit or a 64-bit operand size. Two 6-bit immediates set the field. One is a rotate amount (`rotAmt`) and the other is the number of the field's top bit (`leftBit`). When `leftBit` is at least `rotAmt`, the field is taken from position `rotAmt` and placed at the bottom of the result. This is an extraction. When `leftBit` is smaller than `rotAmt`, the low bits of the source are placed higher up in the result. This is an insertion. Logical shifts by a constant and byte or halfword zero-extension are special cases of the same operation.

Both placements use one datapath. The source is rotated right within the operand size, and the result is then ANDed with two decoded masks. The first is a rotated run of ones that wraps around the element. The second is a low-aligned run of ones that trims the part that wrapped. A control module decodes the masks and the legality of the encoding. It passes them to the datapath as a small struct. Encodings that are not legal raise a flag and force the result to zero. With the default parameter the outputs are registered, so they follow the inputs by one clock. Setting the parameter to zero makes the outputs combinational.

Top module: `bitfield_move_unit`

## Requirements
- R1: With a legal encoding and `leftBit` >= `rotAmt`, result bits [leftBit-rotAmt:0] equal source bits [leftBit:rotAmt].
- R2: With a legal encoding and `leftBit` < `rotAmt`, source bits [leftBit:0] appear at result bits starting at position (size - rotAmt), where size is 32 or 64.
- R3: Every result bit outside the moved field is zero in both the extraction case and the insertion case.
- R4: When `sizeSel`=0, the unit uses only source bits [31:0] and rotates within 32 bits. Source bits [63:32] have no effect on the result.
- R5: `undefFlag` is 1 exactly in two cases. The first is `sizeSel`=1 with `nBit`=0. The second is `sizeSel`=0 with any of `nBit`, `rotAmt[5]` or `leftBit[5]` equal to 1.
- R6: When `sizeSel`=0, result bits [63:32] are zero.
- R7: When `undefFlag` is 1, the whole result is zero.
- R8: `rotAmt`=0 with `leftBit`=7 zero-extends source byte [7:0]. `rotAmt`=0 with `leftBit`=15 zero-extends halfword [15:0].
- R9: `leftBit` = size-1 gives a logical right shift by `rotAmt`. `leftBit`+1 = `rotAmt` gives a left shift by size-1-`leftBit` that is truncated to the operand size.
- R10: When REG_OUT=1, both outputs are zero during reset. After reset they reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| sizeSel | input | 1 | Operand size: 0 = 32-bit, 1 = 64-bit |
| nBit | input | 1 | Mask-width bit; must match `sizeSel` |
| rotAmt | input | 6 | Right-rotate amount |
| leftBit | input | 6 | Number of the leftmost bit to move |
| srcData | input | 64 | Source operand |
| result | output | 64 | Bitfield move result |
| undefFlag | output | 1 | Encoding is not legal |

## Verification
The hardest case to reach is the insertion path that lies right at the wrap boundary. There `rotAmt` is exactly one more than `leftBit`, so the field touches the top bit of the operand. In 32-bit mode the mask that wraps around must also stop at bit 31 and never reach the upper word. A directed sweep drives every `rotAmt`/`leftBit` pair in both sizes, each with a fresh random source, and compares against a model built from plain shifts and masks. A separate test feeds the 32-bit mode sources whose high words differ only in junk bits. It then checks that the results are identical and that the upper word of each result is zero.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  parameter int unsigned XLEN = 64;
  localparam int unsigned HALFLEN = XLEN / 2;
  localparam int unsigned AMT_W = $clog2(XLEN);

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic              is64;
    logic              undef;
    logic [AMT_W-1:0]  rot;
    logic [XLEN-1:0]   wMask;
    logic [XLEN-1:0]   tMask;
  } ctrl_t;

  // Run of n ones at the low end; n may equal XLEN
  function automatic logic [XLEN-1:0] onesLow(input logic [AMT_W:0] n);
    logic [XLEN-1:0] one;
    one = {{(XLEN-1){1'b0}}, 1'b1};
    if (n >= (AMT_W+1)'(XLEN)) return '1;
    return (one << n) - one;
  endfunction
endpackage

// File: rtl/bfmove_ctrl.sv
module bfmove_ctrl
  import bitfield_pkg::*;
(
  input  logic             sizeSel,
  input  logic             nBit,
  input  logic [AMT_W-1:0] rotAmt,
  input  logic [AMT_W-1:0] leftBit,
  output ctrl_t            ctrl
);
  logic [AMT_W-1:0] levels;
  logic [AMT_W-1:0] sVal;
  logic [AMT_W-1:0] rVal;
  logic [AMT_W-1:0] dVal;
  logic [XLEN-1:0]  wElem;
  logic [XLEN-1:0]  tElem;
  logic [2*XLEN-1:0] wDbl;
  logic [XLEN-1:0]  wRot64;
  logic [XLEN-1:0]  wDblHalf;
  logic [HALFLEN-1:0] wRot32;

  always_comb begin
    // Legality of the encoding
    ctrl.is64  = sizeSel;
    ctrl.undef = sizeSel ? !nBit
                         : (nBit | rotAmt[AMT_W-1] | leftBit[AMT_W-1]);

    levels = sizeSel ? AMT_W'(XLEN-1) : AMT_W'(HALFLEN-1);
    sVal   = leftBit & levels;
    rVal   = rotAmt & levels;
    dVal   = (sVal - rVal) & levels;
    ctrl.rot = rVal;

    // Element masks before rotation and replication
    wElem = onesLow({1'b0, sVal} + (AMT_W+1)'(1));
    tElem = onesLow({1'b0, dVal} + (AMT_W+1)'(1));

    // Rotate the wrap element within the operand size
    wDbl     = {wElem, wElem} >> rVal;
    wRot64   = wDbl[XLEN-1:0];
    wDblHalf = {wElem[HALFLEN-1:0], wElem[HALFLEN-1:0]} >> rVal[AMT_W-2:0];
    wRot32   = wDblHalf[HALFLEN-1:0];

    ctrl.wMask = sizeSel ? wRot64 : {wRot32, wRot32};
    ctrl.tMask = sizeSel ? tElem  : {tElem[HALFLEN-1:0], tElem[HALFLEN-1:0]};
  end
endmodule

// File: rtl/bfmove_dpath.sv
module bfmove_dpath
  import bitfield_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] srcData,
  output logic [XLEN-1:0] result,
  output logic            undefFlag
);
  logic [2*XLEN-1:0]  dbl64;
  logic [XLEN-1:0]    dbl32;
  logic [XLEN-1:0]    rotated;
  logic [XLEN-1:0]    masked;
  logic [XLEN-1:0]    nextRes;

  always_comb begin
    dbl64 = {srcData, srcData} >> ctrl.rot;
    dbl32 = {srcData[HALFLEN-1:0], srcData[HALFLEN-1:0]} >> ctrl.rot[AMT_W-2:0];
    rotated = ctrl.is64 ? dbl64[XLEN-1:0]
                        : {{HALFLEN{1'b0}}, dbl32[HALFLEN-1:0]};
    masked = rotated & ctrl.wMask & ctrl.tMask;
    if (ctrl.undef)
      nextRes = '0;
    else if (ctrl.is64)
      nextRes = masked;
    else
      nextRes = {{HALFLEN{1'b0}}, masked[HALFLEN-1:0]};
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result    <= '0;
          undefFlag <= 1'b0;
        end else begin
          result    <= nextRes;
          undefFlag <= ctrl.undef;
        end
      end
    end else begin : g_comb
      assign result    = nextRes;
      assign undefFlag = ctrl.undef;
    end
  endgenerate
endmodule

// File: rtl/bitfield_move_unit.sv
module bitfield_move_unit
  import bitfield_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sizeSel,
  input  logic        nBit,
  input  logic [5:0]  rotAmt,
  input  logic [5:0]  leftBit,
  input  logic [63:0] srcData,
  output logic [63:0] result,
  output logic        undefFlag
);
  ctrl_t ctrl;

  bfmove_ctrl u_ctrl (
    .sizeSel (sizeSel),
    .nBit    (nBit),
    .rotAmt  (rotAmt),
    .leftBit (leftBit),
    .ctrl    (ctrl)
  );

  bfmove_dpath #(.REG_OUT(REG_OUT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcData   (srcData),
    .result    (result),
    .undefFlag (undefFlag)
  );
endmodule

// File: rtl/bfmove_checker.sv
module bfmove_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        sizeSel,
  input logic        nBit,
  input logic [5:0]  rotAmt,
  input logic [5:0]  leftBit,
  input logic [63:0] result,
  input logic        undefFlag
);
  logic       lagSz;
  logic       lagN;
  logic [5:0] lagR;
  logic [5:0] lagS;

  generate
    if (REG_OUT) begin : g_lag
      always_ff @(posedge clk) begin
        if (!rstN) begin
          lagSz <= 1'b0;
          lagN  <= 1'b0;
          lagR  <= '0;
          lagS  <= '0;
        end else begin
          lagSz <= sizeSel;
          lagN  <= nBit;
          lagR  <= rotAmt;
          lagS  <= leftBit;
        end
      end
    end else begin : g_nolag
      assign lagSz = sizeSel;
      assign lagN  = nBit;
      assign lagR  = rotAmt;
      assign lagS  = leftBit;
    end
  endgenerate

  logic       lagBad;
  logic [6:0] extW;
  logic [6:0] lowZ;
  logic [63:0] lowMask;

  always_comb begin
    lagBad  = lagSz ? !lagN : (lagN | lagR[5] | lagS[5]);
    extW    = {1'b0, lagS} - {1'b0, lagR} + 7'd1;
    lowZ    = (lagSz ? 7'd64 : 7'd32) - {1'b0, lagR};
    lowMask = (64'd1 << lowZ[5:0]) - 64'd1;
  end

  AST_UNDEF_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag == lagBad);                                                   // R5
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> result == 64'd0);                                         // R7
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    !lagSz |-> result[63:32] == 32'd0);                                     // R6
  AST_EXTRACT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!lagBad && lagS >= lagR) |-> (result >> extW) == 64'd0);               // R3
  AST_INSERT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!lagBad && lagS < lagR) |-> (result & lowMask) == 64'd0);              // R2
endmodule

bind bitfield_move_unit bfmove_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sizeSel   (sizeSel),
  .nBit      (nBit),
  .rotAmt    (rotAmt),
  .leftBit   (leftBit),
  .result    (result),
  .undefFlag (undefFlag)
);

// File: tb/tb_bitfield_move_unit.sv
module tb_bitfield_move_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sizeSel = 1'b0;
  logic        nBit = 1'b0;
  logic [5:0]  rotAmt = '0;
  logic [5:0]  leftBit = '0;
  logic [63:0] srcData = '0;
  logic [63:0] result;
  logic        undefFlag;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitfield_move_unit #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .nBit(nBit),
    .rotAmt(rotAmt), .leftBit(leftBit), .srcData(srcData),
    .result(result), .undefFlag(undefFlag)
  );

  function automatic logic [63:0] lowOnes(input int w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  // Reference built from shifts and masks
  function automatic logic [63:0] refModel(input logic sf, input logic n,
      input logic [5:0] r, input logic [5:0] s, input logic [63:0] src);
    int size;
    logic [63:0] x;
    if (sf ? !n : (n | r[5] | s[5])) return '0;
    size = sf ? 64 : 32;
    x = sf ? src : {32'd0, src[31:0]};
    if (s >= r) return (x >> r) & lowOnes(int'(s) - int'(r) + 1);
    return ((x & lowOnes(int'(s) + 1)) << (size - int'(r))) & lowOnes(size);
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    chkCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic sf, input logic n, input logic [5:0] r,
                       input logic [5:0] s, input logic [63:0] src);
    sizeSel = sf; nBit = n; rotAmt = r; leftBit = s; srcData = src;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    sizeSel = 1'b1; nBit = 1'b1; rotAmt = 6'd0; leftBit = 6'd63; srcData = '1;
    repeat (3) @(negedge clk);
    check("R10 reset result", result, 64'd0);
    check("R10 reset undef", {63'd0, undefFlag}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 first result after reset", result, '1);
  endtask

  task automatic testSweep(input logic sf);
    int lim;
    lim = sf ? 64 : 32;
    for (int r = 0; r < lim; r++) begin
      for (int s = 0; s < lim; s++) begin
        logic [63:0] src;
        src = rnd64();
        apply(sf, sf, 6'(r), 6'(s), src);
        if (s >= r)
          check(sf ? "R1 R3 sweep64 extract" : "R1 R3 sweep32 extract",
                result, refModel(sf, sf, 6'(r), 6'(s), src));
        else
          check(sf ? "R2 R3 sweep64 insert" : "R2 R3 sweep32 insert",
                result, refModel(sf, sf, 6'(r), 6'(s), src));
        if (!sf) check("R6 upper zero", {32'd0, result[63:32]}, 64'd0);
      end
    end
  endtask

  task automatic testUndef();
    logic [63:0] src;
    src = rnd64();
    apply(1'b1, 1'b0, 6'd3, 6'd9, src);
    check("R5 sf1 n0 flag", {63'd0, undefFlag}, 64'd1);
    check("R7 sf1 n0 zero", result, 64'd0);
    apply(1'b0, 1'b1, 6'd3, 6'd9, src);
    check("R5 sf0 n1 flag", {63'd0, undefFlag}, 64'd1);
    check("R7 sf0 n1 zero", result, 64'd0);
    apply(1'b0, 1'b0, 6'd35, 6'd9, src);
    check("R5 sf0 r5 flag", {63'd0, undefFlag}, 64'd1);
    check("R7 sf0 r5 zero", result, 64'd0);
    apply(1'b0, 1'b0, 6'd3, 6'd40, src);
    check("R5 sf0 s5 flag", {63'd0, undefFlag}, 64'd1);
    check("R7 sf0 s5 zero", result, 64'd0);
    apply(1'b0, 1'b0, 6'd3, 6'd9, src);
    check("R5 sf0 legal flag", {63'd0, undefFlag}, 64'd0);
    apply(1'b1, 1'b1, 6'd40, 6'd50, src);
    check("R5 sf1 legal flag", {63'd0, undefFlag}, 64'd0);
  endtask

  task automatic testAliases();
    logic [63:0] src;
    for (int k = 0; k < 4; k++) begin
      src = rnd64();
      apply(1'b1, 1'b1, 6'd0, 6'd7, src);
      check("R8 byte zext 64", result, {56'd0, src[7:0]});
      apply(1'b0, 1'b0, 6'd0, 6'd15, src);
      check("R8 half zext 32", result, {48'd0, src[15:0]});
      apply(1'b1, 1'b1, 6'(5 + k * 13), 6'd63, src);
      check("R9 lsr 64", result, src >> (5 + k * 13));
      apply(1'b0, 1'b0, 6'(3 + k * 7), 6'd31, src);
      check("R9 lsr 32", result, {32'd0, src[31:0] >> (3 + k * 7)});
      apply(1'b1, 1'b1, 6'(1 + k * 17), 6'(k * 17), src);
      check("R9 lsl 64", result, src << (63 - k * 17));
      apply(1'b0, 1'b0, 6'(1 + k * 9), 6'(k * 9), src);
      check("R9 lsl 32", result, {32'd0, src[31:0] << (31 - k * 9)});
    end
  endtask

  task automatic testUpperIgnored();
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] ra;
    for (int k = 0; k < 4; k++) begin
      a = rnd64();
      b = {~a[63:32], a[31:0]};
      apply(1'b0, 1'b0, 6'(7 + k * 6), 6'(5 + k * 3), a);
      ra = result;
      check("R4 narrow ref", ra, refModel(1'b0, 1'b0, 6'(7 + k * 6), 6'(5 + k * 3), a));
      apply(1'b0, 1'b0, 6'(7 + k * 6), 6'(5 + k * 3), b);
      check("R4 high source ignored", result, ra);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSweep(1'b1);
    testSweep(1'b0);
    testUndef();
    testAliases();
    testUpperIgnored();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule